// File: doc/BRIEF.md
# Capability List Write Commit Gate

This block is the only path by which a capability is stored into a slot of a capability list. A write request carries three things: a source capability (a 32-bit entry plus the 32-bit seal that came with it), the live version of the object it names, and a target list. The target list is given as a base slot and a length inside a small on-block register array, together with an index into that list. The gate runs a fixed sequence of checks, one after another. The first check that fails stops the sequence and sends the gate into a sticky fault state, which only reset can clear.

When every check passes, the gate computes a new seal for the entry, clears the entry's G-bit (the garbage-collection mark) and stores the result. If the target slot already holds an entry with its F-bit set, the slot stands for a forwarded location. In that case the resealed entry leaves on a one-cycle tunnel output and the local array is not written.

Entry layout: bits [15:0] hold the object address, bits [23:16] the flags and bits [31:24] the version. Within the flags, bit 16 is G, bit 17 is B and bit 18 is F. Seals are FNV-1a 32-bit hashes (offset basis 0x811C9DC5, prime 0x01000193). The hash takes one byte per cycle, least significant byte first, and is always computed over the entry with its G-bit forced to zero.

Controller states and their transitions:
- IDLE goes to VERSION on `start`.
- VERSION goes to SEAL_CHECK on a version match, else to FAULT.
- SEAL_CHECK waits for the hash. It goes to BOUNDS on a seal match, else to FAULT.
- BOUNDS goes to BCHECK when in range, else to FAULT.
- BCHECK goes to FCHECK when B is 1, else to FAULT.
- FCHECK samples the target slot's F-bit, starts the reseal and goes to RESEAL.
- RESEAL waits for the hash and goes to GCLEAR.
- GCLEAR clears G and goes to COMMIT.
- COMMIT writes locally or pulses the tunnel, then returns to IDLE.
- FAULT is terminal until reset.

Top module: `cl_commit_gate`

## Requirements
- R1: After reset the gate is idle: `busy`, `done`, `fault` and `tunnel_valid` are 0, `fault_cause` is 0, and every slot reads back entry 0 and seal 0.
- R2: If the version field (bits [31:24]) of the source entry differs from `cur_ver`, the gate faults with `fault_cause` = 1.
- R3: The source seal must equal FNV-1a-32 over the four entry bytes, least significant byte first, with bit 16 forced to 0. Otherwise the gate faults with `fault_cause` = 2.
- R4: If `slot_idx` >= `list_len`, or `list_base` + `slot_idx` >= the slot count (8), the gate faults with `fault_cause` = 3. Otherwise the physical slot is `list_base` + `slot_idx`.
- R5: If the source B-bit (bit 17) is 0, the gate faults with `fault_cause` = 4.
- R6: Checks are applied in the order version, seal, bounds, B-bit. When several would fail, the cause reported is that of the earliest one.
- R7: If the entry currently stored in the target slot has F (bit 18) = 1, a successful write raises `tunnel_valid` for one cycle carrying the resealed entry, its seal and the physical slot. The local slot is left unchanged.
- R8: The new seal is FNV-1a-32 over the four entry bytes (least significant first, bit 16 forced to 0) followed by one byte holding the physical slot number.
- R9: The committed or tunnelled entry equals the source entry with G (bit 16) cleared.
- R10: The array is written only on a successful local write. A faulting request leaves the target slot's entry and seal unchanged.
- R11: Once faulted, the gate stays faulted and ignores `start` (no write, no `done`) until reset.
- R12: Every successful write, local or tunnelled, raises `done` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted in IDLE |
| cur_ver | input | 8 | Live version of the named object |
| src_entry | input | 32 | Source capability entry |
| src_seal | input | 32 | Seal supplied with the source entry |
| list_base | input | 3 | First physical slot of the target list |
| list_len | input | 4 | Number of slots in the target list |
| slot_idx | input | 3 | Index within the target list |
| rd_slot | input | 3 | Read-back slot select |
| rd_entry | output | 32 | Entry stored in `rd_slot` |
| rd_seal | output | 32 | Seal stored in `rd_slot` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse on a successful write |
| fault | output | 1 | Sticky fault indication |
| fault_cause | output | 3 | 0 none, 1 version, 2 seal, 3 bounds, 4 B-bit |
| tunnel_valid | output | 1 | One-cycle pulse for a forwarded write |
| tunnel_entry | output | 32 | Resealed entry on the forwarded path |
| tunnel_seal | output | 32 | New seal on the forwarded path |
| tunnel_slot | output | 3 | Physical slot that was forwarded |

## Verification
The bench builds the gate with its default parameters: eight slots, a 16-bit address, and 8-bit version and flag fields. With only eight slots, every combination of list base (0 to 7), list length (0 to 8) and index (0 to 7) can be swept, which covers both bounds limits and the edge where the list runs past the array end. The small slot count also makes it cheap to seal entries into every physical slot and to sweep a single flipped bit through all 32 positions of the seal. Expected seals come from the bench's own FNV-1a arithmetic, and the ordering cases are built by making two checks fail at once.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
    localparam logic [31:0] FNV_BASIS = 32'h811C9DC5;
    localparam logic [31:0] FNV_PRIME = 32'h01000193;

    // flag bit positions inside the flag field
    localparam int FLAG_G = 0;
    localparam int FLAG_B = 1;
    localparam int FLAG_F = 2;

    typedef enum logic [3:0] {
        S_IDLE, S_VERSION, S_SEAL_CHECK, S_BOUNDS, S_BCHECK,
        S_FCHECK, S_RESEAL, S_GCLEAR, S_COMMIT, S_FAULT
    } gate_state_t;

    typedef enum logic [2:0] {
        C_NONE   = 3'd0,
        C_VER    = 3'd1,
        C_SEAL   = 3'd2,
        C_BOUNDS = 3'd3,
        C_BBIT   = 3'd4
    } fault_cause_t;
endpackage

// File: rtl/cg_fnv_engine.sv
`timescale 1ns/1ps
// Byte-serial FNV-1a 32-bit hasher. A go pulse restarts it; it then
// consumes nbytes bytes of word, lowest byte first, one per cycle, and
// pulses done once the final product is in hash.
module cg_fnv_engine
    import cg_pkg::*;
#(
    parameter int MAXB = 5,
    localparam int CW = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [8*MAXB-1:0] word,
    input  logic [CW-1:0]     nbytes,
    output logic [31:0]       hash,
    output logic              done
);
    logic          active;
    logic [CW-1:0] cnt;
    logic [7:0]    cur_byte;
    logic          last;

    assign cur_byte = word[int'(cnt)*8 +: 8];
    assign last     = (cnt == nbytes - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hash   <= FNV_BASIS;
            cnt    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                hash   <= FNV_BASIS;
                cnt    <= '0;
                active <= 1'b1;
            end else if (active) begin
                hash <= (hash ^ {24'h0, cur_byte}) * FNV_PRIME;
                if (last) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: a finished hash always follows a running pass
    assert_done_after_run_R8: assert property (
        @(posedge clk) disable iff (!rst_n) done |-> $past(active));

    // R3: a restart always leaves the engine running next cycle
    assert_go_starts_R3: assert property (
        @(posedge clk) disable iff (!rst_n) go |=> active);
endmodule

// File: rtl/cg_slot_store.sv
`timescale 1ns/1ps
// Register array of capability slots: one write port, two read ports
// (one for read-back, one for the target-slot F-bit probe).
module cg_slot_store #(
    parameter int SLOTS   = 8,
    parameter int ENTRY_W = 32,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wentry,
    input  logic [31:0]        wseal,
    input  logic [IDX_W-1:0]   ra_addr,
    output logic [ENTRY_W-1:0] ra_entry,
    output logic [31:0]        ra_seal,
    input  logic [IDX_W-1:0]   rb_addr,
    output logic [ENTRY_W-1:0] rb_entry
);
    logic [ENTRY_W-1:0] ent_q  [SLOTS];
    logic [31:0]        seal_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                ent_q[i]  <= '0;
                seal_q[i] <= '0;
            end
        end else if (we) begin
            ent_q[waddr]  <= wentry;
            seal_q[waddr] <= wseal;
        end
    end

    assign ra_entry = ent_q[ra_addr];
    assign ra_seal  = seal_q[ra_addr];
    assign rb_entry = ent_q[rb_addr];

    // R10: a write strobe lands its data in the addressed slot
    assert_commit_lands_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(we) |-> (ent_q[$past(waddr)] == $past(wentry)
                       && seal_q[$past(waddr)] == $past(wseal)));
endmodule

// File: rtl/cg_commit_seq.sv
`timescale 1ns/1ps
// Check-and-commit sequencer: latches a request, walks the checks in
// fixed order, drives the hasher twice (validate, reseal) and commits.
module cg_commit_seq
    import cg_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 16,
    parameter int VER_W  = 8,
    parameter int FLAG_W = 8,
    localparam int IDX_W   = $clog2(SLOTS),
    localparam int ENTRY_W = ADDR_W + FLAG_W + VER_W,
    localparam int NB      = ENTRY_W / 8,
    localparam int MAXB    = NB + 1,
    localparam int CW      = $clog2(MAXB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VER_W-1:0]   cur_ver,
    input  logic [ENTRY_W-1:0] src_entry,
    input  logic [31:0]        src_seal,
    input  logic [IDX_W-1:0]   list_base,
    input  logic [IDX_W:0]     list_len,
    input  logic [IDX_W-1:0]   slot_idx,
    input  logic [31:0]        hash,
    input  logic               hash_done,
    output logic               hash_go,
    output logic [8*MAXB-1:0]  hash_word,
    output logic [CW-1:0]      hash_nbytes,
    input  logic [ENTRY_W-1:0] tgt_entry,
    output logic [IDX_W-1:0]   tgt_addr,
    output logic               st_we,
    output logic [IDX_W-1:0]   st_addr,
    output logic [ENTRY_W-1:0] st_entry,
    output logic [31:0]        st_seal,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [2:0]         fault_cause,
    output logic               tunnel_valid,
    output logic [ENTRY_W-1:0] tunnel_entry,
    output logic [31:0]        tunnel_seal,
    output logic [IDX_W-1:0]   tunnel_slot
);
    localparam int G_POS  = ADDR_W + FLAG_G;
    localparam int B_POS  = ADDR_W + FLAG_B;
    localparam int F_POS  = ADDR_W + FLAG_F;
    localparam int VER_LO = ADDR_W + FLAG_W;
    localparam logic [IDX_W:0]     SLOT_LIMIT = (IDX_W + 1)'(SLOTS);
    localparam logic [ENTRY_W-1:0] G_MASK     = ~(ENTRY_W'(1) << G_POS);

    gate_state_t  state, nxt;
    fault_cause_t cause_q, nxt_cause;

    logic [ENTRY_W-1:0] l_entry;
    logic [31:0]        l_seal;
    logic [VER_W-1:0]   l_ver;
    logic [IDX_W-1:0]   l_base;
    logic [IDX_W:0]     l_len;
    logic [IDX_W-1:0]   l_idx;
    logic               l_fwd;
    logic [31:0]        new_seal;

    logic [IDX_W:0]     phys_wide;
    logic [IDX_W-1:0]   phys;
    logic               in_bounds;
    logic               ver_ok;
    logic [ENTRY_W-1:0] masked;
    logic               src_phase;

    assign phys_wide = {1'b0, l_base} + {1'b0, l_idx};
    assign phys      = phys_wide[IDX_W-1:0];
    assign in_bounds = ({1'b0, l_idx} < l_len) && (phys_wide < SLOT_LIMIT);
    assign ver_ok    = (l_entry[VER_LO +: VER_W] == l_ver);
    assign masked    = l_entry & G_MASK;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt       = state;
        nxt_cause = C_NONE;
        unique case (state)
            S_IDLE:       if (start) nxt = S_VERSION;
            S_VERSION: begin
                if (ver_ok) nxt = S_SEAL_CHECK;
                else begin
                    nxt       = S_FAULT;
                    nxt_cause = C_VER;
                end
            end
            S_SEAL_CHECK: begin
                if (hash_done) begin
                    if (hash == l_seal) nxt = S_BOUNDS;
                    else begin
                        nxt       = S_FAULT;
                        nxt_cause = C_SEAL;
                    end
                end
            end
            S_BOUNDS: begin
                if (in_bounds) nxt = S_BCHECK;
                else begin
                    nxt       = S_FAULT;
                    nxt_cause = C_BOUNDS;
                end
            end
            S_BCHECK: begin
                if (l_entry[B_POS]) nxt = S_FCHECK;
                else begin
                    nxt       = S_FAULT;
                    nxt_cause = C_BBIT;
                end
            end
            S_FCHECK:     nxt = S_RESEAL;
            S_RESEAL:     if (hash_done) nxt = S_GCLEAR;
            S_GCLEAR:     nxt = S_COMMIT;
            S_COMMIT:     nxt = S_IDLE;
            S_FAULT:      nxt = S_FAULT;
            default:      nxt = S_IDLE;
        endcase
    end

    // ---------------- request datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_entry  <= '0;
            l_seal   <= '0;
            l_ver    <= '0;
            l_base   <= '0;
            l_len    <= '0;
            l_idx    <= '0;
            l_fwd    <= 1'b0;
            new_seal <= '0;
            cause_q  <= C_NONE;
        end else begin
            if (state == S_IDLE && start) begin
                l_entry <= src_entry;
                l_seal  <= src_seal;
                l_ver   <= cur_ver;
                l_base  <= list_base;
                l_len   <= list_len;
                l_idx   <= slot_idx;
            end
            if (nxt == S_FAULT && state != S_FAULT) cause_q <= nxt_cause;
            if (state == S_FCHECK) l_fwd <= tgt_entry[F_POS];
            if (state == S_RESEAL && hash_done) new_seal <= hash;
            if (state == S_GCLEAR) l_entry[G_POS] <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    assign src_phase = (state == S_VERSION) || (state == S_SEAL_CHECK);

    always_comb begin
        hash_go      = (state == S_VERSION && ver_ok) || (state == S_FCHECK);
        hash_word    = src_phase ? {8'h00, masked} : {8'(phys), masked};
        hash_nbytes  = src_phase ? CW'(NB) : CW'(MAXB);
        tgt_addr     = phys;
        st_we        = (state == S_COMMIT) && !l_fwd;
        st_addr      = phys;
        st_entry     = l_entry;
        st_seal      = new_seal;
        busy         = (state != S_IDLE) && (state != S_FAULT);
        done         = (state == S_COMMIT);
        fault        = (state == S_FAULT);
        fault_cause  = cause_q;
        tunnel_valid = (state == S_COMMIT) && l_fwd;
        tunnel_entry = l_entry;
        tunnel_seal  = new_seal;
        tunnel_slot  = phys;
    end

    // R11: the fault state is never left without reset
    assert_fault_sticky_R11: assert property (
        @(posedge clk) disable iff (!rst_n) fault |=> fault);

    // R6: a fault always names the stage that stopped the request
    assert_fault_named_R6: assert property (
        @(posedge clk) disable iff (!rst_n) fault |-> (fault_cause != C_NONE));

    // R12: completion is a single-cycle pulse
    assert_done_single_R12: assert property (
        @(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/cl_commit_gate.sv
`timescale 1ns/1ps
module cl_commit_gate
    import cg_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 16,
    parameter int VER_W  = 8,
    parameter int FLAG_W = 8,
    localparam int IDX_W   = $clog2(SLOTS),
    localparam int ENTRY_W = ADDR_W + FLAG_W + VER_W,
    localparam int MAXB    = ENTRY_W / 8 + 1,
    localparam int CW      = $clog2(MAXB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VER_W-1:0]   cur_ver,
    input  logic [ENTRY_W-1:0] src_entry,
    input  logic [31:0]        src_seal,
    input  logic [IDX_W-1:0]   list_base,
    input  logic [IDX_W:0]     list_len,
    input  logic [IDX_W-1:0]   slot_idx,
    input  logic [IDX_W-1:0]   rd_slot,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic [31:0]        rd_seal,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [2:0]         fault_cause,
    output logic               tunnel_valid,
    output logic [ENTRY_W-1:0] tunnel_entry,
    output logic [31:0]        tunnel_seal,
    output logic [IDX_W-1:0]   tunnel_slot
);
    localparam int G_POS = ADDR_W + FLAG_G;

    logic               hash_go, hash_done;
    logic [8*MAXB-1:0]  hash_word;
    logic [CW-1:0]      hash_nbytes;
    logic [31:0]        hash;
    logic [ENTRY_W-1:0] tgt_entry;
    logic [IDX_W-1:0]   tgt_addr;
    logic               st_we;
    logic [IDX_W-1:0]   st_addr;
    logic [ENTRY_W-1:0] st_entry;
    logic [31:0]        st_seal;

    cg_commit_seq #(
        .SLOTS(SLOTS), .ADDR_W(ADDR_W), .VER_W(VER_W), .FLAG_W(FLAG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_ver(cur_ver),
        .src_entry(src_entry), .src_seal(src_seal),
        .list_base(list_base), .list_len(list_len), .slot_idx(slot_idx),
        .hash(hash), .hash_done(hash_done), .hash_go(hash_go),
        .hash_word(hash_word), .hash_nbytes(hash_nbytes),
        .tgt_entry(tgt_entry), .tgt_addr(tgt_addr),
        .st_we(st_we), .st_addr(st_addr), .st_entry(st_entry), .st_seal(st_seal),
        .busy(busy), .done(done), .fault(fault), .fault_cause(fault_cause),
        .tunnel_valid(tunnel_valid), .tunnel_entry(tunnel_entry),
        .tunnel_seal(tunnel_seal), .tunnel_slot(tunnel_slot)
    );

    cg_fnv_engine #(.MAXB(MAXB)) u_fnv (
        .clk(clk), .rst_n(rst_n), .go(hash_go), .word(hash_word),
        .nbytes(hash_nbytes), .hash(hash), .done(hash_done)
    );

    cg_slot_store #(.SLOTS(SLOTS), .ENTRY_W(ENTRY_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_addr),
        .wentry(st_entry), .wseal(st_seal),
        .ra_addr(rd_slot), .ra_entry(rd_entry), .ra_seal(rd_seal),
        .rb_addr(tgt_addr), .rb_entry(tgt_entry)
    );

    // R9: nothing reaches the array with its G-bit still set
    assert_gbit_clear_R9: assert property (
        @(posedge clk) disable iff (!rst_n) st_we |-> !st_entry[G_POS]);

    // R7: a forwarded write leaves the probed target slot untouched
    assert_tunnel_keeps_slot_R7: assert property (
        @(posedge clk) disable iff (!rst_n) tunnel_valid |=> $stable(tgt_entry));
endmodule

// File: tb/sim_cl_commit_gate.sv
`timescale 1ns/1ps
module sim_cl_commit_gate;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, start;
    logic [7:0]  cur_ver;
    logic [31:0] src_entry, src_seal;
    logic [2:0]  list_base, slot_idx, rd_slot;
    logic [3:0]  list_len;
    logic [31:0] rd_entry, rd_seal;
    logic        busy, done, fault, tunnel_valid;
    logic [2:0]  fault_cause, tunnel_slot;
    logic [31:0] tunnel_entry, tunnel_seal;

    cl_commit_gate u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_ver(cur_ver),
        .src_entry(src_entry), .src_seal(src_seal), .list_base(list_base),
        .list_len(list_len), .slot_idx(slot_idx), .rd_slot(rd_slot),
        .rd_entry(rd_entry), .rd_seal(rd_seal), .busy(busy), .done(done),
        .fault(fault), .fault_cause(fault_cause), .tunnel_valid(tunnel_valid),
        .tunnel_entry(tunnel_entry), .tunnel_seal(tunnel_seal),
        .tunnel_slot(tunnel_slot)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fnv(input logic [39:0] w, input int n);
        logic [31:0] h = 32'h811C9DC5;
        for (int i = 0; i < n; i++) h = (h ^ {24'h0, w[8*i +: 8]}) * 32'h01000193;
        return h;
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] v, input logic [7:0] f, input logic [15:0] a);
        return {v, f, a};
    endfunction

    function automatic logic [31:0] nog(input logic [31:0] e);
        return e & 32'hFFFE_FFFF;
    endfunction

    function automatic logic [31:0] seal_src(input logic [31:0] e);
        return fnv({8'h00, nog(e)}, 4);
    endfunction

    function automatic logic [31:0] seal_new(input logic [31:0] e, input logic [2:0] s);
        return fnv({5'b0, s, nog(e)}, 5);
    endfunction

    bit          r_done, r_fault, r_tv, r_to;
    logic [31:0] r_te, r_ts;
    logic [2:0]  r_tslot;

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic txn(input logic [7:0] cv, input logic [31:0] e, input logic [31:0] s,
                       input logic [2:0] b, input logic [3:0] l, input logic [2:0] ix);
        @(negedge clk);
        cur_ver = cv; src_entry = e; src_seal = s;
        list_base = b; list_len = l; slot_idx = ix;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_done = 0; r_fault = 0; r_tv = 0; r_to = 1;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                r_done = 1; r_tv = tunnel_valid; r_te = tunnel_entry;
                r_ts = tunnel_seal; r_tslot = tunnel_slot; r_to = 0;
                break;
            end
            if (fault) begin
                r_fault = 1; r_to = 0;
                break;
            end
            @(negedge clk);
        end
        if (r_done) begin
            @(negedge clk);
            chk("R12 done pulse width", {63'h0, done}, 64'h0);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] e, output logic [31:0] sl);
        rd_slot = s;
        #0.5;
        e  = rd_entry;
        sl = rd_seal;
    endtask

    task automatic expect_fault(input string req, input logic [2:0] cause);
        chk({req, " fault raised"}, {63'h0, r_fault}, 64'h1);
        chk({req, " fault cause"}, {61'h0, fault_cause}, {61'h0, cause});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] e, s, e2, e_f, ge, gs;
        rd_slot = 0; cur_ver = 0; src_entry = 0; src_seal = 0;
        list_base = 0; list_len = 0; slot_idx = 0;
        do_reset();
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {63'h0, busy}, 0);
        chk("R1 done", {63'h0, done}, 0);
        chk("R1 fault", {63'h0, fault}, 0);
        chk("R1 tunnel_valid", {63'h0, tunnel_valid}, 0);
        chk("R1 fault_cause", {61'h0, fault_cause}, 0);
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), ge, gs);
            chk("R1 slot clear", {ge, gs}, 0);
        end

        // R8 R9 R10 basic local commit, G set in source
        e = mk(8'h05, 8'h03, 16'hBEEF);
        txn(8'h05, e, seal_src(e), 3'd2, 4'd4, 3'd1);
        chk("R10 commit done", {62'h0, r_done, r_fault}, 64'h2);
        chk("R7 no tunnel on plain slot", {63'h0, r_tv}, 0);
        rd(3'd3, ge, gs);
        chk("R9 G cleared in stored entry", {32'h0, ge}, {32'h0, mk(8'h05, 8'h02, 16'hBEEF)});
        chk("R8 stored seal", {32'h0, gs}, {32'h0, seal_new(e, 3'd3)});

        // R2 version mismatch, R10 slot unchanged, R11 sticky
        e2 = mk(8'h06, 8'h02, 16'h1111);
        txn(8'h05, e2, seal_src(e2), 3'd2, 4'd4, 3'd1);
        expect_fault("R2", 3'd1);
        rd(3'd3, ge, gs);
        chk("R10 slot kept on fault", {ge, gs}, {mk(8'h05, 8'h02, 16'hBEEF), seal_new(e, 3'd3)});
        e2 = mk(8'h05, 8'h02, 16'h2222);
        txn(8'h05, e2, seal_src(e2), 3'd2, 4'd4, 3'd1);
        chk("R11 no done while faulted", {63'h0, r_done}, 0);
        chk("R11 still faulted", {60'h0, busy, fault, fault_cause}, {60'h0, 1'b0, 1'b1, 3'd1});
        rd(3'd3, ge, gs);
        chk("R11 slot kept while faulted", {32'h0, ge}, {32'h0, mk(8'h05, 8'h02, 16'hBEEF)});

        // R6 ordering: two failing checks at once
        do_reset();
        e = mk(8'h07, 8'h02, 16'h0042);
        txn(8'h05, e, seal_src(e) ^ 32'h1, 3'd0, 4'd8, 3'd0);
        expect_fault("R6 version before seal", 3'd1);
        do_reset();
        e = mk(8'h05, 8'h02, 16'h0042);
        txn(8'h05, e, seal_src(e) ^ 32'h8000_0000, 3'd0, 4'd2, 3'd5);
        expect_fault("R6 seal before bounds", 3'd2);
        do_reset();
        e = mk(8'h05, 8'h00, 16'h0042);
        txn(8'h05, e, seal_src(e), 3'd6, 4'd4, 3'd3);
        expect_fault("R6 bounds before B-bit", 3'd3);
        do_reset();
        txn(8'h05, e, seal_src(e), 3'd0, 4'd8, 3'd0);
        expect_fault("R5 B-bit clear", 3'd4);
        rd(3'd0, ge, gs);
        chk("R10 slot kept on B-bit fault", {ge, gs}, 0);

        // R7 forwarded slot
        do_reset();
        e_f = mk(8'h05, 8'h06, 16'h1234);
        txn(8'h05, e_f, seal_src(e_f), 3'd4, 4'd1, 3'd0);
        chk("R7 setup commit", {62'h0, r_done, r_tv}, 64'h2);
        e2 = mk(8'h05, 8'h03, 16'h5678);
        txn(8'h05, e2, seal_src(e2), 3'd0, 4'd8, 3'd4);
        chk("R7 tunnel pulse", {62'h0, r_done, r_tv}, 64'h3);
        chk("R7 R9 tunnel entry", {32'h0, r_te}, {32'h0, mk(8'h05, 8'h02, 16'h5678)});
        chk("R7 R8 tunnel seal", {32'h0, r_ts}, {32'h0, seal_new(e2, 3'd4)});
        chk("R7 tunnel slot", {61'h0, r_tslot}, 64'd4);
        rd(3'd4, ge, gs);
        chk("R7 local slot untouched", {ge, gs}, {e_f, seal_new(e_f, 3'd4)});
        e2 = mk(8'h05, 8'h01, 16'h5678);
        txn(8'h05, e2, seal_src(e2), 3'd0, 4'd8, 3'd4);
        expect_fault("R6 B-bit before forward", 3'd4);

        // R3 R8 R9 seal arithmetic over every slot and G value
        do_reset();
        for (int k = 0; k < 32; k++) begin
            logic [7:0] fl;
            fl = 8'h02 | 8'(k & 1) | 8'(k & 8'hF0);
            e = mk(8'(8'h30 + k), fl, 16'(k * 16'h0931 + 16'h7A5));
            txn(8'(8'h30 + k), e, seal_src(e), 3'd0, 4'd8, 3'(k));
            chk("R3 valid seal accepted", {62'h0, r_done, r_fault}, 64'h2);
            rd(3'(k), ge, gs);
            chk("R9 entry stored", {32'h0, ge}, {32'h0, nog(e)});
            chk("R8 seal stored", {32'h0, gs}, {32'h0, seal_new(e, 3'(k))});
        end

        // R3 single flipped seal bit at every position
        for (int k = 0; k < 32; k++) begin
            do_reset();
            e = mk(8'h11, 8'h03, 16'(16'h0100 + k));
            txn(8'h11, e, seal_src(e) ^ (32'h1 << k), 3'd0, 4'd8, 3'd1);
            expect_fault("R3 seal bit flip", 3'd2);
        end

        // R4 bounds sweep over every base, length and index
        for (int b = 0; b < 8; b++)
            for (int l = 0; l < 9; l++)
                for (int ix = 0; ix < 8; ix++) begin
                    bit ok;
                    do_reset();
                    ok = (ix < l) && (b + ix < 8);
                    e = mk(8'h09, 8'h02, 16'(b * 256 + l * 16 + ix));
                    txn(8'h09, e, seal_src(e), 3'(b), 4'(l), 3'(ix));
                    if (ok) begin
                        chk("R4 in-range accepted", {62'h0, r_done, r_fault}, 64'h2);
                        rd(3'(b + ix), ge, gs);
                        chk("R4 stored at base+index", {ge, gs}, {e, seal_new(e, 3'(b + ix))});
                    end else begin
                        expect_fault("R4 out of range", 3'd3);
                        if (b + ix < 8) begin
                            rd(3'(b + ix), ge, gs);
                            chk("R10 R4 slot kept", {ge, gs}, 0);
                        end
                    end
                end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule